// File: doc/BRIEF.md
# Programmable Power-of-Two Clock Divider

The block takes one fast input clock and puts out either that clock itself or a divided copy of it. The divided copy has a 50% duty cycle and goes out on two identical true/complement output pairs. A 3-bit select picks pass-through or division by 2, 4, 8 or 16. In the divide modes the ratio in force changes only when the internal counter wraps, so a new select value never shortens a pulse.

A single active-low control input does two jobs. In the divide modes it clears the counter asynchronously and holds the outputs static. In pass-through mode it acts as an output enable. That enable is sampled on the falling edge of the input clock, so the gated clock starts and stops without a runt pulse. While the control is low, the select is loaded on every rising edge, so the ratio in force after release is the one currently selected.

Top module: `pow2_clk_div`

## Requirements
- R1: Select decoding: 000 gives pass-through, 001 gives ÷2, 010 gives ÷4, 011 gives ÷8, and every code from 100 to 111 gives ÷16.
- R2: In a ÷N mode, the true output is high after rising input edges N/2 to N-1 (counted modulo N from the release of reset) and low otherwise. It changes only just after a rising input edge.
- R3: In a divide mode, driving rst_ni low forces the true outputs low and the complements high at once, with no clock edge needed, and holds them there while rst_ni stays low.
- R4: In pass-through mode with the enable set, the true outputs are high during the high phase of clk_i and low during its low phase.
- R5: In pass-through mode, rst_ni is sampled at each falling edge of clk_i. A low sample holds the true outputs low and the complements high from that edge on. A high sample lets the clock through again from that edge on. A change in rst_ni during a high phase has no effect before the next falling edge.
- R6: q0_o always equals q1_o, and q0_n_o and q1_n_o are always their complements.
- R7: In a divide mode with rst_ni high, a new select value takes effect only at the rising edge that completes the current output period. The new ratio then starts from a count of zero.
- R8: While rst_ni is low, the select is loaded at every rising edge of clk_i, so the ratio in force after release is the select present at the last rising edge before release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Active-low divider clear (divide modes) and output enable (pass-through) |
| sel_i | input | 3 | Ratio select |
| q0_o | output | 1 | Output pair 0, true |
| q0_n_o | output | 1 | Output pair 0, complement |
| q1_o | output | 1 | Output pair 1, true |
| q1_n_o | output | 1 | Output pair 1, complement |

## Verification
The assertions assume that rst_ni and sel_i change only during the high phase of clk_i and well clear of both edges. Under that assumption, the value the falling-edge enable flop captures and the select the counter loads are both unambiguous. The stimulus drives every input change two time units after a rising edge, inside a ten-unit period. Random select codes cover all eight values, and reset pulses are placed at random, so both the async-clear path and the pass-through enable path are exercised under that same timing.

// File: rtl/pow2_div_pkg.sv
package pow2_div_pkg;
  localparam int unsigned MAX_SHIFT = 4;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned SHIFT_W   = $clog2(MAX_SHIFT + 1);
  typedef logic [SHIFT_W-1:0] shift_t;
endpackage

// File: rtl/div_sel_decode.sv
module div_sel_decode #(
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned MAX_SHIFT = 4,
  parameter int unsigned SHIFT_W   = 3
) (
  input  logic [SEL_W-1:0]   sel_i,
  output logic [SHIFT_W-1:0] shift_o
);
  always_comb begin
    if (sel_i >= SEL_W'(MAX_SHIFT)) shift_o = SHIFT_W'(MAX_SHIFT);
    else                            shift_o = SHIFT_W'(sel_i);
  end
endmodule

// File: rtl/div_counter.sv
module div_counter #(
  parameter int unsigned MAX_SHIFT = 4,
  parameter int unsigned SHIFT_W   = 3
) (
  input  logic               clk_i,
  input  logic               arst_ni,
  input  logic               load_i,
  input  logic [SHIFT_W-1:0] shift_req_i,
  output logic [SHIFT_W-1:0] shift_o,
  output logic               div_o
);
  localparam int unsigned CNT_W = MAX_SHIFT;

  logic [SHIFT_W-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d, mask, half;
  logic [CNT_W:0]     span_q, span_d;
  logic               wrap, out_q, out_d;

  assign span_q = (CNT_W+1)'(1) << shift_q;
  assign mask   = span_q[CNT_W-1:0] - CNT_W'(1);
  assign wrap   = (cnt_q == mask);

  // ratio switches only at period end (or while reset is held)
  assign shift_d = (wrap || load_i) ? shift_req_i : shift_q;
  assign cnt_d   = wrap ? '0 : cnt_q + CNT_W'(1);
  assign span_d  = (CNT_W+1)'(1) << shift_d;
  assign half    = span_d[CNT_W:1];
  assign out_d   = |(cnt_d & half);

  always_ff @(posedge clk_i) shift_q <= shift_d;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign shift_o = shift_q;
  assign div_o   = out_q;
endmodule

// File: rtl/clk_out_stage.sv
module clk_out_stage (
  input  logic clk_i,
  input  logic en_i,
  input  logic pass_i,
  input  logic div_i,
  output logic q0_o,
  output logic q0_n_o,
  output logic q1_o,
  output logic q1_n_o
);
  logic en_q, mux_out;

  // enable captured while clk is low side of the edge: no runt on gating
  always_ff @(negedge clk_i) en_q <= en_i;

  assign mux_out = pass_i ? (clk_i & en_q) : div_i;
  assign q0_o    = mux_out;
  assign q1_o    = mux_out;
  assign q0_n_o  = ~mux_out;
  assign q1_n_o  = ~mux_out;
endmodule

// File: rtl/pow2_clk_div.sv
module pow2_clk_div
  import pow2_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             q0_o,
  output logic             q0_n_o,
  output logic             q1_o,
  output logic             q1_n_o
);
  shift_t req_shift, act_shift;
  logic   pass_mode, div_arst_n, div_clk;

  div_sel_decode #(.SEL_W(SEL_W), .MAX_SHIFT(MAX_SHIFT), .SHIFT_W(SHIFT_W)) u_dec (
    .sel_i   (sel_i),
    .shift_o (req_shift)
  );

  assign pass_mode  = (act_shift == '0);
  assign div_arst_n = rst_ni | pass_mode;

  div_counter #(.MAX_SHIFT(MAX_SHIFT), .SHIFT_W(SHIFT_W)) u_cnt (
    .clk_i       (clk_i),
    .arst_ni     (div_arst_n),
    .load_i      (~rst_ni),
    .shift_req_i (req_shift),
    .shift_o     (act_shift),
    .div_o       (div_clk)
  );

  clk_out_stage u_out (
    .clk_i  (clk_i),
    .en_i   (rst_ni),
    .pass_i (pass_mode),
    .div_i  (div_clk),
    .q0_o   (q0_o),
    .q0_n_o (q0_n_o),
    .q1_o   (q1_o),
    .q1_n_o (q1_n_o)
  );
endmodule

// File: rtl/pow2_clk_div_chk.sv
module pow2_clk_div_chk
  import pow2_div_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input shift_t act_shift,
  input logic   q0_o,
  input logic   q0_n_o,
  input logic   q1_o,
  input logic   q1_n_o
);
  p_fanout_match_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q0_o == q1_o) && (q0_n_o == ~q0_o) && (q1_n_o == ~q1_o));

  p_reset_hold_r3: assert property (@(posedge clk_i)
    (!rst_ni && act_shift != '0) |-> (!q0_o && q0_n_o));

  p_div2_toggle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_shift == shift_t'(1) && $past(act_shift) == shift_t'(1) && $past(rst_ni))
      |-> (q0_o != $past(q0_o)));

  p_pass_follow_r4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (act_shift == '0 && $past(act_shift) == '0 && $past(rst_ni)) |-> q0_o);
endmodule

bind pow2_clk_div pow2_clk_div_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .act_shift (act_shift),
  .q0_o      (q0_o),
  .q0_n_o    (q0_n_o),
  .q1_o      (q1_o),
  .q1_n_o    (q1_n_o)
);

// File: tb/pow2_clk_div_tb_top.sv
module pow2_clk_div_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'b111;
  logic       q0, q0n, q1, q1n;
  logic       neg_en = 1'b0;
  int         n_chk = 0, n_fail = 0;
  int         m_shift = 4, m_cnt = 0;
  bit         done = 1'b0;

  always #(HALF) clk = ~clk;
  always @(negedge clk) neg_en <= rst_n;

  pow2_clk_div dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel),
    .q0_o(q0), .q0_n_o(q0n), .q1_o(q1), .q1_n_o(q1n)
  );

  function automatic int dec(input logic [2:0] s);
    return (s >= 3'd4) ? 4 : int'(s);
  endfunction

  function automatic logic exp_div(input int sh, input int c);
    return (c >= ((1 << sh) / 2));
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // rising edge, then update model and compare 1 unit later
  task automatic tick();
    logic e;
    @(posedge clk);
    #1;
    if (!rst_n) begin
      m_shift = dec(sel);                       // R8
      if (m_shift != 0) m_cnt = 0;
    end else if (m_cnt == (1 << m_shift) - 1) begin
      m_cnt = 0;
      m_shift = dec(sel);                       // R7
    end else m_cnt++;
    if (!rst_n && m_shift != 0) m_cnt = 0;
    e = (m_shift == 0) ? neg_en : (rst_n ? exp_div(m_shift, m_cnt) : 1'b0);
    chk((m_shift == 0) ? "R4/R5" : "R2/R7", q0, e);
    chk("R6", q1, q0);
    chk("R6", q0n, ~q0);
    chk("R6", q1n, ~q0);
  endtask

  task automatic drive(input logic r, input logic [2:0] s);
    #1;                                         // posedge+2
    rst_n = r;
    sel = s;
    if (!r && m_shift != 0) m_cnt = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) tick();
    chk("R3", q0, 1'b0);
    chk("R3", q0n, 1'b1);

    // R1 R2: every ratio, periods from release
    for (int s = 0; s < 8; s++) begin
      drive(1'b0, 3'(s));
      tick(); tick();
      drive(1'b1, 3'(s));
      chk("R1", 1'(m_shift == dec(3'(s))), 1'b1);
      repeat (40) tick();
      drive(1'b1, 3'(s));
    end

    // R3: async clear mid-period in /16 while output high
    drive(1'b0, 3'b100); tick(); drive(1'b1, 3'b100);
    repeat (10) tick();
    chk("R3 pre", q0, 1'b1);
    drive(1'b0, 3'b100);
    #1;
    chk("R3", q0, 1'b0);
    chk("R3", q0n, 1'b1);
    repeat (3) tick();

    // R7: switch /16 -> /2 mid-period, old ratio finishes first
    drive(1'b1, 3'b100);
    repeat (5) tick();
    drive(1'b1, 3'b001);
    repeat (30) tick();

    // R4 R5: pass-through gating at falling edge
    drive(1'b0, 3'b000); tick();
    drive(1'b1, 3'b000);
    repeat (3) tick();
    @(negedge clk); #1;
    chk("R4", q0, 1'b0);
    tick();
    drive(1'b0, 3'b000);
    #1;
    chk("R5 high-phase", q0, 1'b1);
    @(negedge clk); #1;
    chk("R5", q0, 1'b0);
    tick();
    chk("R5 disabled", q0, 1'b0);
    chk("R5 disabled", q0n, 1'b1);
    drive(1'b1, 3'b000);
    #1;
    chk("R5 still off", q0, 1'b0);
    tick();
    chk("R5 re-enabled", q0, 1'b1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic r;
      logic [2:0] s;
      r = ($urandom_range(0, 19) != 0);
      s = ($urandom_range(0, 7) == 0) ? 3'($urandom_range(0, 7)) : sel;
      drive(r, s);
      tick();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule